// File: doc/BRIEF.md
# Two-Wire Serial Slave Memory Port with Write Guard

This block lets an external two-wire bus master read and write a small byte-wide on-chip memory. The serial clock and data lines are oversampled by the system clock through a synchronizer. Start, repeated start and stop conditions are found by watching SDA change while SCL is high. The block then answers to one 7-bit device address, takes bytes MSB first, and acknowledges them. Finally it turns the bus traffic into one-cycle read and write strobes on a synchronous memory port.

A write transfer sends the device address with the direction bit low, then one word-address byte, then any number of data bytes. The data bytes land at consecutive locations, and the address wraps at the top of the array. A read transfer, usually entered through a repeated start after the word address has been set, returns bytes from the current address onward. It continues until the master answers a byte with no acknowledge. The slave only ever pulls SDA low, through `sda_oe`, and never drives SCL. A write-guard input blocks memory writes, either to the whole array or to the upper half only, as a parameter selects.

The memory port has no back-pressure. Each strobe lasts one cycle, and the memory must accept it in that cycle. Read data is expected on `mem_rdata` in the cycle after `mem_re`. Each SCL high and low phase must last at least six system clock cycles.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, and whenever no transfer is open (before the first start, or after a stop), `sda_oe` is 0. Bits clocked without a preceding start draw no acknowledge.
- R2: The device address is {DEV_HI (default 4'b1010), dev_pins[2:0]}, sent in bits 7:1 of the first byte after a start, with the direction bit in bit 0 (0 = write, 1 = read). On a match the slave holds SDA low during the ninth clock. On a mismatch SDA stays released for the rest of the transfer.
- R3: In a write transfer, the byte after the device address loads the word address from its low AW bits. Each following byte is acknowledged and written with one `mem_we` pulse, with `mem_addr` equal to the current word address.
- R4: The word address increases by one after each data byte written or read, and wraps modulo 2^AW.
- R5: In a read transfer, the slave pulses `mem_re` and shifts out the byte at the current address, MSB first. A master acknowledge (SDA low) starts the next byte. A no-acknowledge releases SDA, and the slave leaves it released until the next start or stop.
- R6: While `wp` is 1, data bytes aimed at protected locations are still acknowledged but raise no `mem_we`. Protected locations are all addresses when PROTECT_ALL is 1, and addresses whose bit AW-1 is 1 when PROTECT_ALL is 0. Reads are never affected.
- R7: A repeated start is handled exactly like a start and keeps the word address, so a write of the word address followed by a repeated start can read from that address.
- R8: A start or stop that arrives before the eighth bit of a byte discards the partial byte. No write occurs, and the slave goes back to waiting for a device address, or to idle.
- R9: `sda_oe` changes only while SCL is low.
- R10: `mem_we` and `mem_re` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level from the pad |
| sda_in | input | 1 | Serial data line level from the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_pins | input | 3 | Strapped low three bits of the device address |
| wp | input | 1 | Write guard, active high |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe; data due next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
A bit counter that is off by one moves the acknowledge into a data bit, and the master sees that at its next ninth clock, within nine SCL periods. A wrong word-address register or a wrong increment shows up as a wrong byte on the bus, or a write to the wrong location, no later than the next data byte; sweeps over every location make either fault visible. A wrong protection decode shows up as an extra or a missing `mem_we` during a guarded burst. A state machine that fails to leave its data states on a stop or a no-acknowledge keeps SDA pulled low, and this appears on the very next bit the master reads.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN,
    ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WADR,
    PH_DATA
  } ph_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } bus_ev_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_mem_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  // SDA moving while SCL stays high marks a bus condition, never a data bit
  assign ev.start = scl_s & scl_q & sda_q & ~sda_s;
  assign ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
  assign ev.rise  = scl_s & ~scl_q;
  assign ev.fall  = ~scl_s & scl_q;
  assign ev.sda   = sda_s;
endmodule

// File: rtl/i2c_wp_guard.sv
module i2c_wp_guard #(
  parameter bit PROTECT_ALL = 1'b0
) (
  input  logic wp,
  input  logic addr_msb,
  output logic blocked
);
  generate
    if (PROTECT_ALL) begin : g_all
      logic unused_msb;
      assign unused_msb = addr_msb;
      assign blocked    = wp;
    end else begin : g_half
      assign blocked = wp & addr_msb;
    end
  endgenerate
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0] DEV_HI      = 4'b1010,
  parameter int         AW          = 4,
  parameter bit         PROTECT_ALL = 1'b0,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [2:0]    dev_pins,
  input  logic          wp,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST_RX = CW'(BITS);
  localparam logic [CW-1:0] LAST_TX = CW'(BITS - 1);

  bus_ev_t ev;
  st_e st;
  ph_e ph;
  logic rw_q, acked_q, load_q, blocked;
  logic [CW-1:0] cnt;
  logic [7:0] rx_sr, tx_sr;
  logic [AW-1:0] addr_q;
  logic [6:0] my_addr;

  assign my_addr  = {DEV_HI, dev_pins};
  assign mem_addr = addr_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
  );

  i2c_wp_guard #(.PROTECT_ALL(PROTECT_ALL)) u_guard (
    .wp(wp), .addr_msb(addr_q[AW-1]), .blocked(blocked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_DEV;
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      addr_q    <= '0;
      rw_q      <= 1'b0;
      acked_q   <= 1'b0;
      load_q    <= 1'b0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      load_q <= mem_re;
      if (load_q) tx_sr <= mem_rdata;
      if (ev.start) begin
        // start and repeated start alike: drop any partial byte
        st     <= ST_RX;
        ph     <= PH_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (ev.stop) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (ev.rise && cnt != LAST_RX) begin
              rx_sr <= {rx_sr[6:0], ev.sda};
              cnt   <= cnt + 1'b1;
            end else if (ev.fall && cnt == LAST_RX) begin
              cnt <= '0;
              case (ph)
                PH_DEV: begin
                  if (rx_sr[7:1] == my_addr) begin
                    rw_q   <= rx_sr[0];
                    st     <= ST_ACK_OUT;
                    sda_oe <= 1'b1;
                    mem_re <= rx_sr[0];
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                PH_WADR: begin
                  addr_q <= rx_sr[AW-1:0];
                  st     <= ST_ACK_OUT;
                  sda_oe <= 1'b1;
                end
                default: begin
                  mem_wdata <= rx_sr;
                  mem_we    <= ~blocked;
                  st        <= ST_ACK_OUT;
                  sda_oe    <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK_OUT: begin
            if (ev.fall) begin
              if (rw_q) begin
                st     <= ST_TX;
                cnt    <= '0;
                sda_oe <= ~tx_sr[7];
              end else begin
                st     <= ST_RX;
                sda_oe <= 1'b0;
                if (ph == PH_DATA) addr_q <= addr_q + 1'b1;
                ph <= (ph == PH_DEV) ? PH_WADR : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (ev.fall) begin
              if (cnt == LAST_TX) begin
                st     <= ST_ACK_IN;
                cnt    <= '0;
                sda_oe <= 1'b0;
                addr_q <= addr_q + 1'b1;
              end else begin
                cnt    <= cnt + 1'b1;
                tx_sr  <= {tx_sr[6:0], 1'b0};
                sda_oe <= ~tx_sr[6];
              end
            end
          end
          ST_ACK_IN: begin
            if (ev.rise) begin
              acked_q <= ~ev.sda;
              mem_re  <= ~ev.sda;
            end else if (ev.fall) begin
              if (acked_q) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sr[7];
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW          = 4,
  parameter bit PROTECT_ALL = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          wp,
  input logic          mem_we,
  input logic          mem_re,
  input logic          idle,
  input logic [AW-1:0] mem_addr
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);
  assert_guard_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(wp && (PROTECT_ALL || mem_addr[AW-1])));
  assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_in);
  assert_we_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  assert_re_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);
  assert_strobes_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(AW), .PROTECT_ALL(PROTECT_ALL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .wp(wp),
  .mem_we(mem_we), .mem_re(mem_re), .idle(st == i2c_mem_pkg::ST_IDLE),
  .mem_addr(mem_addr)
);

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] PINS = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, PINS, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, PINS, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe, mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  int n_vec = 0, n_bad = 0, we_count = 0;
  logic [7:0] store [DEPTH];
  logic [7:0] expm [DEPTH];

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .dev_pins(PINS), .wp(wp), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  // simple synchronous memory on the far side of the port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= 8'h00;
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) begin
        store[mem_addr] <= mem_wdata;
        we_count <= we_count + 1;
      end
      if (mem_re) mem_rdata <= store[mem_addr];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(4); scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4); b = sda_line; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic go_start();
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4); sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic go_stop();
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(8);
  endtask

  task automatic put_byte(input logic [7:0] v, output int ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = b ? 0 : 1;
  endtask

  task automatic get_byte(input logic ack_it, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack_it);
  endtask

  function automatic logic [7:0] pattern(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 3) & 255);
  endfunction

  task automatic wr_burst(input int a0, input int n, input int seed, input string tag);
    int ack;
    logic [7:0] v;
    int a;
    go_start();
    put_byte(DEV_W, ack);  chk({tag, " dev ack"}, ack, 1);
    put_byte(8'(a0), ack); chk({tag, " word addr ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      v = pattern(seed, k);
      a = (a0 + k) % DEPTH;
      put_byte(v, ack);
      chk({tag, " data ack"}, ack, 1);
      if (!(wp && a >= DEPTH / 2)) expm[a] = v;
    end
    go_stop();
  endtask

  task automatic rd_burst(input int a0, input int n, input string tag);
    int ack;
    logic [7:0] v;
    go_start();
    put_byte(DEV_W, ack);
    put_byte(8'(a0), ack);
    go_start();  // R7: repeated start keeps the word address
    put_byte(DEV_R, ack); chk({tag, " R7 read dev ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, v);
      chk({tag, " R4 R5 read data"}, int'(v), int'(expm[(a0 + k) % DEPTH]));
    end
    chk("R5 released after no-ack", int'(sda_oe), 0);
    get_byte(1'b0, v);
    chk("R5 line stays released", int'(v), 8'hFF);
    go_stop();
  endtask

  task automatic cmp_store(input string tag);
    for (int i = 0; i < DEPTH; i++) chk(tag, int'(store[i]), int'(expm[i]));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int ack, we0;
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) expm[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state and no response on a free bus
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 mem_we after reset", int'(mem_we), 0);
    chk("R1 mem_re after reset", int'(mem_re), 0);
    put_byte(DEV_W, ack);
    chk("R1 no ack without start", ack, 0);
    tick(8);

    // R2: sweep all strapped-bit values, plus a wrong upper nibble
    for (int lo = 0; lo < 8; lo++) begin
      go_start();
      put_byte({4'b1010, 3'(lo), 1'b0}, ack);
      chk("R2 address match ack", ack, (lo == int'(PINS)) ? 1 : 0);
      if (lo != int'(PINS)) begin
        put_byte(8'h00, ack);
        chk("R2 mismatch stays silent", ack, 0);
      end
      go_stop();
    end
    go_start();
    put_byte({4'b1011, PINS, 1'b0}, ack);
    chk("R2 wrong upper bits", ack, 0);
    go_stop();

    // R3 R4: full-array write burst wrapping past the top
    we0 = we_count;
    wr_burst(5, DEPTH, 1, "R3");
    chk("R10 one strobe per byte", we_count - we0, DEPTH);
    cmp_store("R3 R4 stored value");

    // R5 R4 R7: read whole array, crossing the wrap
    rd_burst(9, DEPTH, "R5");

    // R6: guard on upper half
    wp = 1'b1;
    we0 = we_count;
    wr_burst(0, DEPTH, 2, "R6");
    chk("R6 strobes only below half", we_count - we0, DEPTH / 2);
    cmp_store("R6 stored value");
    rd_burst(12, 6, "R6 read unaffected");
    wp = 1'b0;

    // R8: stop in mid-byte discards it
    go_start();
    put_byte(DEV_W, ack);
    put_byte(8'd3, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    go_stop();
    chk("R8 aborted byte not written", int'(store[3]), int'(expm[3]));

    // R8: repeated start in mid-byte, then a clean write
    go_start();
    put_byte(DEV_W, ack);
    put_byte(8'd7, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    go_start();
    put_byte(DEV_W, ack);  chk("R8 R7 ack after restart", ack, 1);
    put_byte(8'd2, ack);
    put_byte(8'hC3, ack);
    expm[2] = 8'hC3;
    go_stop();
    tick(4);
    chk("R8 write after restart", int'(store[2]), 8'hC3);
    chk("R8 partial byte dropped", int'(store[7]), int'(expm[7]));
    chk("R1 idle after stop", int'(sda_oe), 0);

    summary();
    $finish;
  end
endmodule